// File: doc/BRIEF.md
# Result Bus Slot Scheduler

This block decides which functional unit may take a selected operation when all units share one tag bus and one data bus for their results. Units have fixed but different latencies. A unit that wants to start an operation raises a request with the operation's latency `k` (in cycles) and its destination tag. The scheduler keeps a row of future bus slots in a shift register that moves forward by one position per clock. It grants the request only if the data slot `k` cycles ahead is still free. Bus conflicts are therefore settled when an operation starts, never when its result is ready.

Once an operation is granted, no further input is needed. The scheduler drives the tag bus enable and tag one cycle before the result, which lets waiting consumers wake up early. It then drives the data bus enable, the tag and the index of the unit that owns the data bus in that cycle. A flush input removes every outstanding reservation.

Each unit's request is a valid/ready pair. `req_ready` is computed within the cycle from the unit's own request and the current reservations. A transfer happens when both `req_valid` and `req_ready` are high at a clock edge. A refused unit is not committed to anything. It may keep its request raised, change its latency or tag, or drop the request in the next cycle. No request is queued inside the block, so back-pressure is simply the absence of ready.

Top module: `rbs_result_sched`

## Requirements
- R1: While reset is active and after its release with no requests, `tag_bus_valid` and `data_bus_valid` are low.
- R2: A request from unit u with latency k and tag t granted in cycle n makes `data_bus_valid` high in cycle n+k with `data_bus_tag` = t and `data_bus_unit` = u. In cycles with no reservation due, `data_bus_valid` is low.
- R3: That grant makes `tag_bus_valid` high with `tag_bus_tag` = t in cycle n+k-1. For k = 1 this is the grant cycle itself. In cycles with no tag due, `tag_bus_valid` is low.
- R4: A request is refused when its data cycle n+k is already reserved by an earlier grant. This also covers the tag cycle n+k-1. A refused request causes no bus activity.
- R5: Among requests in the same cycle, units are considered from index 0 upward. A request whose data cycle was taken by a lower-index grant in that cycle is refused. Requests with different latencies are all granted.
- R6: The latency field is unsigned. A latency of 0, or a latency above `MAX_LAT`, is always refused.
- R7: `req_ready[u]` is never high while `req_valid[u]` is low.
- R8: In a cycle with `flush` high, no request is granted and `tag_bus_valid` is low. The data bus still carries any result due in that cycle. All later reservations are cancelled, so `data_bus_valid` stays low from the next cycle until a new grant comes due.
- R9: One unit granted every cycle with the same latency gets a result on the data bus in every consecutive cycle. There are no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Cancel all reservations, block grants this cycle |
| req_valid | input | NUM_UNITS | Per unit: an operation asks to start |
| req_ready | output | NUM_UNITS | Per unit: the request is granted this cycle |
| req_lat | input | NUM_UNITS*LAT_W | Per unit latency, unit u at bits [u*LAT_W +: LAT_W] |
| req_tag | input | NUM_UNITS*6 | Per unit destination tag, unit u at bits [u*6 +: 6] |
| tag_bus_valid | output | 1 | Tag bus enable |
| tag_bus_tag | output | 6 | Tag being broadcast |
| data_bus_valid | output | 1 | Data bus enable |
| data_bus_tag | output | 6 | Tag of the result on the data bus |
| data_bus_unit | output | 3 | Unit that drives the data bus this cycle |

## Verification
Single requests are tried at latency 1, at a middle latency and at `MAX_LAT`. These show whether the tag-before-data offset holds at both ends, including the case where the tag goes out in the grant cycle. Paired requests are then sent, either across cycles or in the same cycle, with colliding or distinct target cycles. These separate refusals caused by earlier reservations from refusals caused by lower-index grants in the same cycle, and they confirm that different latencies coexist. A back-to-back stream at latency 1 checks full bus use. A flush with reservations pending checks that the current result survives while later ones are dropped. A long pseudo-random mix of latencies, including illegal ones, with occasional flushes, is compared against a cycle-indexed scoreboard.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  // Width of a result tag carried on the tag and data buses.
  localparam int TAG_W  = 6;
  // Width of a functional-unit index (up to 8 units).
  localparam int UNIT_W = 3;

  // One future bus slot: who drives the data bus in that cycle.
  typedef struct packed {
    logic              busy;
    logic [UNIT_W-1:0] unit;
    logic [TAG_W-1:0]  tag;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '0;

endpackage

// File: rtl/rbs_arbiter.sv
// Grants requests against the current slot occupancy, lowest unit first.
module rbs_arbiter #(
  parameter int NUM_UNITS = 4,
  parameter int MAX_LAT   = 8,
  parameter int LAT_W     = 4
) (
  input  logic [NUM_UNITS-1:0]             req_valid,
  input  logic [NUM_UNITS*LAT_W-1:0]       req_lat,
  input  logic                             flush,
  input  logic [MAX_LAT:1]                 occ,
  output logic [NUM_UNITS-1:0]             grant,
  output logic [NUM_UNITS-1:0][MAX_LAT:1]  wr
);

  // One-hot latency per unit; bit 0 marks the illegal latency zero,
  // and values above MAX_LAT decode to all zeros.
  logic [NUM_UNITS-1:0][MAX_LAT:0] lat_oh;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    for (genvar k = 0; k <= MAX_LAT; k++) begin : g_bit
      assign lat_oh[u][k] = (req_lat[u*LAT_W +: LAT_W] == LAT_W'(k));
    end
  end

  logic [MAX_LAT:0] claimed;

  always_comb begin
    claimed = {occ, 1'b1};
    grant   = '0;
    wr      = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      grant[u] = req_valid[u] && !flush && (|(lat_oh[u] & ~claimed));
      if (grant[u]) begin
        claimed = claimed | lat_oh[u];
        wr[u]   = lat_oh[u][MAX_LAT:1];
      end
    end
  end

endmodule

// File: rtl/rbs_slot_ring.sv
// Shift register of reserved bus slots. Slot j holds the owner of the
// data bus j cycles from now; slot 0 is the current data bus.
module rbs_slot_ring
  import rbs_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int MAX_LAT   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [NUM_UNITS-1:0][MAX_LAT:1]  wr,
  input  logic [NUM_UNITS*TAG_W-1:0]       req_tag,
  output slot_t                            head,
  output logic [MAX_LAT:1]                 occ,
  output logic [TAG_W-1:0]                 next_tag
);

  slot_t slot_q [MAX_LAT];
  slot_t slot_d [MAX_LAT];
  slot_t view   [MAX_LAT+1];

  for (genvar j = 0; j < MAX_LAT; j++) begin : g_view
    assign view[j] = slot_q[j];
  end
  assign view[MAX_LAT] = SLOT_EMPTY;

  // A grant of latency k lands in slot k-1 after this edge, so it
  // reaches slot 0 exactly k cycles after the grant.
  always_comb begin
    for (int j = 0; j < MAX_LAT; j++) begin
      slot_d[j] = view[j+1];
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (wr[u][j+1]) begin
          slot_d[j] = '{busy: 1'b1,
                        unit: UNIT_W'(u),
                        tag:  req_tag[u*TAG_W +: TAG_W]};
        end
      end
      if (flush) slot_d[j] = SLOT_EMPTY;
    end
  end

  for (genvar j = 0; j < MAX_LAT; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[j] <= SLOT_EMPTY;
      else        slot_q[j] <= slot_d[j];
    end
  end

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_occ
    assign occ[k] = view[k].busy;
  end

  assign head     = view[0];
  assign next_tag = view[1].tag;

endmodule

// File: rtl/rbs_tag_drive.sv
// Tag bus: the slot due next cycle, or a latency-1 grant made now.
module rbs_tag_drive
  import rbs_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                        next_busy,
  input  logic [TAG_W-1:0]            next_tag,
  input  logic [NUM_UNITS-1:0]        fast,
  input  logic [NUM_UNITS*TAG_W-1:0]  req_tag,
  input  logic                        flush,
  output logic                        tag_valid,
  output logic [TAG_W-1:0]            tag
);

  always_comb begin
    tag_valid = 1'b0;
    tag       = '0;
    if (!flush) begin
      if (next_busy) begin
        tag_valid = 1'b1;
        tag       = next_tag;
      end
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (fast[u]) begin
          tag_valid = 1'b1;
          tag       = req_tag[u*TAG_W +: TAG_W];
        end
      end
    end
  end

endmodule

// File: rtl/rbs_result_sched.sv
module rbs_result_sched
  import rbs_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int MAX_LAT   = 8,
  localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [NUM_UNITS-1:0]        req_valid,
  output logic [NUM_UNITS-1:0]        req_ready,
  input  logic [NUM_UNITS*LAT_W-1:0]  req_lat,
  input  logic [NUM_UNITS*TAG_W-1:0]  req_tag,
  output logic                        tag_bus_valid,
  output logic [TAG_W-1:0]            tag_bus_tag,
  output logic                        data_bus_valid,
  output logic [TAG_W-1:0]            data_bus_tag,
  output logic [UNIT_W-1:0]           data_bus_unit
);

  logic [MAX_LAT:1]                occ;
  logic [NUM_UNITS-1:0][MAX_LAT:1] wr;
  logic [NUM_UNITS-1:0]            fast;
  slot_t                           head;
  logic [TAG_W-1:0]                next_tag;

  rbs_arbiter #(
    .NUM_UNITS (NUM_UNITS),
    .MAX_LAT   (MAX_LAT),
    .LAT_W     (LAT_W)
  ) u_arb (
    .req_valid (req_valid),
    .req_lat   (req_lat),
    .flush     (flush),
    .occ       (occ),
    .grant     (req_ready),
    .wr        (wr)
  );

  rbs_slot_ring #(
    .NUM_UNITS (NUM_UNITS),
    .MAX_LAT   (MAX_LAT)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr       (wr),
    .req_tag  (req_tag),
    .head     (head),
    .occ      (occ),
    .next_tag (next_tag)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_fast
    assign fast[u] = wr[u][1];
  end

  rbs_tag_drive #(
    .NUM_UNITS (NUM_UNITS)
  ) u_tag (
    .next_busy (occ[1]),
    .next_tag  (next_tag),
    .fast      (fast),
    .req_tag   (req_tag),
    .flush     (flush),
    .tag_valid (tag_bus_valid),
    .tag       (tag_bus_tag)
  );

  assign data_bus_valid = head.busy;
  assign data_bus_tag   = head.tag;
  assign data_bus_unit  = head.unit;

endmodule

// File: rtl/rbs_result_sched_chk.sv
module rbs_result_sched_chk
  import rbs_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int MAX_LAT   = 8,
  localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flush,
  input logic [NUM_UNITS-1:0]        req_valid,
  input logic [NUM_UNITS-1:0]        req_ready,
  input logic [NUM_UNITS*LAT_W-1:0]  req_lat,
  input logic                        tag_bus_valid,
  input logic [TAG_W-1:0]            tag_bus_tag,
  input logic                        data_bus_valid,
  input logic [TAG_W-1:0]            data_bus_tag
);

  logic lat1_grant;
  logic bad_lat_grant;
  logic same_lat_pair;

  always_comb begin
    lat1_grant    = 1'b0;
    bad_lat_grant = 1'b0;
    same_lat_pair = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (req_ready[u] && req_lat[u*LAT_W +: LAT_W] == LAT_W'(1)) lat1_grant = 1'b1;
      if (req_ready[u] && (req_lat[u*LAT_W +: LAT_W] == '0 ||
                           req_lat[u*LAT_W +: LAT_W] > LAT_W'(MAX_LAT)))
        bad_lat_grant = 1'b1;
      for (int v = u + 1; v < NUM_UNITS; v++) begin
        if (req_ready[u] && req_ready[v] &&
            req_lat[u*LAT_W +: LAT_W] == req_lat[v*LAT_W +: LAT_W])
          same_lat_pair = 1'b1;
      end
    end
  end

  // R3
  tag_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_bus_valid |=> data_bus_valid && data_bus_tag == $past(tag_bus_tag));

  // R2
  data_had_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_bus_valid |-> $past(tag_bus_valid));

  // R3
  fast_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat1_grant |-> tag_bus_valid);

  // R5
  no_shared_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !same_lat_pair);

  // R6
  bad_lat_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_lat_grant);

  // R7
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R8
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> req_ready == '0 && !tag_bus_valid);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_bus_valid);

endmodule

bind rbs_result_sched rbs_result_sched_chk #(
  .NUM_UNITS (NUM_UNITS),
  .MAX_LAT   (MAX_LAT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush          (flush),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_lat        (req_lat),
  .tag_bus_valid  (tag_bus_valid),
  .tag_bus_tag    (tag_bus_tag),
  .data_bus_valid (data_bus_valid),
  .data_bus_tag   (data_bus_tag)
);

// File: tb/test_rbs_result_sched.sv
module test_rbs_result_sched;
  import rbs_pkg::*;

  localparam int N  = 4;
  localparam int ML = 8;
  localparam int LW = $clog2(ML + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [N-1:0]      req_ready;
  logic [N*LW-1:0]   req_lat = '0;
  logic [N*TAG_W-1:0] req_tag = '0;
  logic              tag_bus_valid;
  logic [TAG_W-1:0]  tag_bus_tag;
  logic              data_bus_valid;
  logic [TAG_W-1:0]  data_bus_tag;
  logic [UNIT_W-1:0] data_bus_unit;

  rbs_result_sched #(.NUM_UNITS(N), .MAX_LAT(ML)) i_rbs_result_sched (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lat(req_lat), .req_tag(req_tag),
    .tag_bus_valid(tag_bus_valid), .tag_bus_tag(tag_bus_tag),
    .data_bus_valid(data_bus_valid), .data_bus_tag(data_bus_tag),
    .data_bus_unit(data_bus_unit)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int data_seen = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  bit s_v [N];
  int s_lat [N];
  int s_tag [N];

  typedef struct {int dcyc; int gcyc; int tag; int unit;} item_t;
  item_t sb [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int find(int c);
    for (int j = 0; j < sb.size(); j++) if (sb[j].dcyc == c) return j;
    return -1;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic want(int u, int lat, int tag);
    s_v[u] = 1'b1; s_lat[u] = lat; s_tag[u] = tag;
  endtask

  // Driver: apply staged requests for one cycle, predict grants, push
  // expected bus items into the scoreboard.
  task automatic step(bit fl);
    @(negedge clk);
    flush = fl;
    for (int i = 0; i < N; i++) begin
      req_valid[i] = s_v[i];
      req_lat[i*LW +: LW] = LW'(s_lat[i]);
      req_tag[i*TAG_W +: TAG_W] = TAG_W'(s_tag[i]);
    end
    #1;
    if (fl) begin
      for (int j = sb.size() - 1; j >= 0; j--) if (sb[j].dcyc > cyc) sb.delete(j);
    end
    for (int i = 0; i < N; i++) begin
      bit exp;
      string why;
      int hit;
      exp = 1'b0;
      why = "R2";
      if (!s_v[i]) why = "R7";
      else if (fl) why = "R8";
      else if (s_lat[i] < 1 || s_lat[i] > ML) why = "R6";
      else begin
        hit = find(cyc + s_lat[i]);
        if (hit < 0) exp = 1'b1;
        else why = (sb[hit].gcyc == cyc) ? "R5" : "R4";
      end
      chk(req_ready[i] == exp, why, $sformatf("ready unit %0d", i), int'(req_ready[i]), int'(exp));
      if (exp) sb.push_back('{cyc + s_lat[i], cyc, s_tag[i], i});
    end
    for (int i = 0; i < N; i++) s_v[i] = 1'b0;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) step(1'b0);
  endtask

  // Monitor: compare both buses with the scoreboard every cycle.
  always @(negedge clk) begin
    #2;
    if (mon_on) begin : mon
      int d;
      int t;
      d = find(cyc);
      t = find(cyc + 1);
      if (t >= 0) begin
        chk(tag_bus_valid == 1'b1, "R3", "tag valid", int'(tag_bus_valid), 1);
        chk(int'(tag_bus_tag) == sb[t].tag, "R3", "tag value", int'(tag_bus_tag), sb[t].tag);
      end else begin
        chk(tag_bus_valid == 1'b0, "R3", "tag idle", int'(tag_bus_valid), 0);
      end
      if (data_bus_valid) data_seen++;
      if (d >= 0) begin
        chk(data_bus_valid == 1'b1, "R2", "data valid", int'(data_bus_valid), 1);
        chk(int'(data_bus_tag) == sb[d].tag, "R2", "data tag", int'(data_bus_tag), sb[d].tag);
        chk(int'(data_bus_unit) == sb[d].unit, "R2", "data unit", int'(data_bus_unit), sb[d].unit);
        sb.delete(d);
      end else begin
        chk(data_bus_valid == 1'b0, "R2", "data idle", int'(data_bus_valid), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      summary();
    end
  end

  initial begin
    int base;
    logic [15:0] lfsr;
    int tagc;
    for (int i = 0; i < N; i++) begin s_v[i] = 1'b0; s_lat[i] = 0; s_tag[i] = 0; end

    // R1: quiet buses in reset and right after release
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(tag_bus_valid == 1'b0, "R1", "tag in reset", int'(tag_bus_valid), 0);
    chk(data_bus_valid == 1'b0, "R1", "data in reset", int'(data_bus_valid), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // Single requests at a middle latency, latency 1 and MAX_LAT (R2, R3)
    want(0, 3, 5);  step(1'b0); idle(5);
    want(1, 1, 9);  step(1'b0); idle(3);
    want(2, ML, 17); step(1'b0); idle(ML + 2);

    // Conflicts with earlier reservations (R4)
    want(0, 4, 20); step(1'b0);
    want(1, 3, 21); want(2, 2, 22); step(1'b0);
    idle(5);
    want(0, 2, 23); step(1'b0);
    want(1, 1, 24); step(1'b0);   // tag cycle already in use
    idle(4);

    // Same-cycle priority and differing latencies (R5)
    want(0, 2, 30); want(2, 2, 31); want(3, 5, 32); step(1'b0);
    idle(6);

    // Illegal latencies (R6)
    want(0, 0, 40); want(1, 9, 41); want(2, 15, 42); want(3, ML, 43); step(1'b0);
    idle(ML + 2);

    // Flush with pending reservations (R8)
    want(0, 5, 50); step(1'b0);
    want(1, 6, 51); step(1'b0);
    want(2, 1, 52); step(1'b0);
    want(3, 2, 53); step(1'b1);
    idle(ML + 2);

    // Back-to-back latency-1 stream (R9)
    base = data_seen;
    for (int j = 0; j < 12; j++) begin want(j % N, 1, 60 - j); step(1'b0); end
    idle(2);
    chk(data_seen - base == 12, "R9", "results in stream", data_seen - base, 12);

    // Pseudo-random mix (R2 R3 R4 R5 R6 R8)
    lfsr = 16'hACE1;
    tagc = 0;
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < N; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0] ^ lfsr[5]) begin
          want(i, int'(lfsr[11:8]) % 11, tagc % 64);
          tagc++;
        end
      end
      step((lfsr % 16'd53) == 16'd0);
    end
    idle(ML + 2);

    done = 1'b1;
    summary();
  end

endmodule